// File: doc/BRIEF.md
# Flow-Through Late-Write SRAM Core

This block is a synchronous static RAM. A read and a write can follow each other on every clock with no idle cycle between them. Every control, address and lane-mask input is registered on the rising clock edge. These registers only update when the active-low clock enable is low.

A read returns its word in the cycle right after its address edge. The path from the storage array to the output is combinational, so the read data is "flow-through". A write takes its address at one edge and its data at the next enabled edge. A different command can be issued on that second edge.

The data bus is split into three signals so that it can be synthesized:
- a data-in word;
- a data-out word;
- a drive-enable flag, which stands in for the output buffer.

The drive-enable is held low at these times, whatever the asynchronous output enable says:
- during the data cycle of a write;
- while the core is deselected;
- during the first access after a deselect;
- while the core sleeps.

The word is 4 lanes of 9 bits. A lane is 8 data bits plus one parity bit, and each lane has its own active-low write select. Burst address sequencing lives outside this block. The `cont` input only keeps the class of the previous command (read, write or deselect) and uses the address now presented.

Two state machines control the core:
- **Command machine.** States: DESEL, READ, WRITE.
  - With `cont` low, a fresh decode picks READ or WRITE when all three selects are active, and DESEL otherwise.
  - With `cont` high, each state moves back to itself (the CONTINUE transition).
  - A stalled edge leaves the state unchanged.
  - A sleep force sends any state to DESEL.
- **Power machine.** States: AWAKE, ENTER, ASLEEP, LEAVE.
  - AWAKE→ENTER when sleep is seen high.
  - ENTER→ASLEEP when sleep is still high; ENTER→AWAKE when it has dropped.
  - ASLEEP→LEAVE when sleep is seen low.
  - LEAVE→AWAKE when sleep is still low; LEAVE→ASLEEP when it rose again.

Top module: `ftlw_sram`

## Requirements
- R1: A command is accepted only at an edge with `clk_en_n` low. With `cont` low, it is an access only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. `we_n`=1 then means read and `we_n`=0 means write. Any other select value deselects, and no write takes place.
- R2: After a read is accepted, the next cycle drives `drive_en`=1 and `rdata` = the stored word at the sampled address. This requires `oe_n` low and that the read is not the first access after a deselect.
- R3: The write data on `wdata` is stored at the next enabled edge after the write's address edge. A read issued on that same edge returns the new data, merged lane by lane.
- R4: Lane i of a word is bits [9i+8:9i]. Lane i is written only if `lane_wr_n[i]` was 0 at the address edge; other lanes keep their contents. All four bits at 1 makes the write a no-op.
- R5: An edge with `clk_en_n` high changes nothing: command, address, pending write and memory are all held. The write is done at the next enabled edge, and a read keeps driving its word.
- R6: `drive_en` is 0 during a write data cycle and while deselected, whatever `oe_n` is. `rdata` is all-zero whenever `drive_en` is 0.
- R7: The data cycle of the first command accepted after a deselected cycle never drives, even when that command is a read.
- R8: `oe_n` high forces `drive_en` low within the same cycle, without waiting for a clock edge.
- R9: After reset the core is deselected with `drive_en`=0.
- R10: With `cont` high at an enabled edge, the command class of the previous edge is kept and the new `addr` and `lane_wr_n` are used. The selects and `we_n` are ignored. After a deselect, `cont` keeps the core deselected.
- R11: Sleep takes effect at the second consecutive edge that sees `sleep` high. At that edge any pending write is dropped and the core becomes deselected. Commands are then ignored until two consecutive edges have seen `sleep` low. Memory contents are kept and the outputs stay undriven after waking. A single-edge pulse of `sleep` has no effect on accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low edge qualifier; high stalls the core |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| cont | input | 1 | Keep the previous command class with a new address |
| we_n | input | 1 | Low selects write, high selects read |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken one enabled edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Low-power request |
| rdata | output | LANES*LANE_W | Read word; zero when not driven |
| drive_en | output | 1 | High when the core would drive the shared bus |

## Verification
The bench goes after these corner cases, and each has a telltale failure:
- **Write immediately followed by a read of the same address.** A core that wrote late, or read the array before the write landed, would return the stale word.
- **Stalled edges between a write's address and its data.** A core that committed on a stalled edge would store whatever data sat on the bus during the stall.
- **The first read after a deselect.** A core that let this read drive would contend with another device still releasing the bus.
- **A write whose data edge coincides with sleep entry.** A core that still performed it would alter memory. Reads after waking show whether this happened and whether the old contents survived.
- **Continue cycles whose selects and write flag contradict the running command.** A core that decoded them afresh would switch between read and write in the middle of a sequence.

// File: rtl/ftlw_pkg.sv
package ftlw_pkg;

    // class of the command whose data phase is current
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } op_e;

    // low-power sequencing
    typedef enum logic [1:0] {
        PW_AWAKE  = 2'd0,
        PW_ENTER  = 2'd1,
        PW_ASLEEP = 2'd2,
        PW_LEAVE  = 2'd3
    } pw_e;

endpackage

// File: rtl/ftlw_sleep_ctl.sv
module ftlw_sleep_ctl
    import ftlw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic force_idle,
    output logic asleep
);

    pw_e pw_q, pw_d;

    always_comb begin
        pw_d = pw_q;
        unique case (pw_q)
            PW_AWAKE:  if (sleep) pw_d = PW_ENTER;
            PW_ENTER:  pw_d = sleep ? PW_ASLEEP : PW_AWAKE;
            PW_ASLEEP: if (!sleep) pw_d = PW_LEAVE;
            PW_LEAVE:  pw_d = sleep ? PW_ASLEEP : PW_AWAKE;
            default:   pw_d = PW_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= PW_AWAKE;
        else        pw_q <= pw_d;
    end

    always_comb begin
        asleep     = (pw_q == PW_ASLEEP) || (pw_q == PW_LEAVE);
        force_idle = asleep || (pw_d == PW_ASLEEP);
    end

    // R11: entering takes two edges
    a_r11_enter_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q == PW_AWAKE) |=> (pw_q != PW_ASLEEP));

    // R11: leaving takes two edges
    a_r11_leave_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q == PW_ASLEEP) |=> (pw_q != PW_AWAKE));

endmodule

// File: rtl/ftlw_cmd_ctl.sv
module ftlw_cmd_ctl
    import ftlw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              force_idle,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              cont,
    input  logic              we_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  lanes_q,
    output logic              first_q,
    output logic              wr_fire
);

    op_e  fresh, state_d;
    logic selected, advance;

    always_comb begin
        selected = !cs1_n && cs2 && !cs3_n;
        advance  = !clk_en_n && !force_idle;
        if (!selected)  fresh = ST_DESEL;
        else if (we_n)  fresh = ST_READ;
        else            fresh = ST_WRITE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL: state_d = cont ? ST_DESEL : fresh;
            ST_READ:  state_d = cont ? ST_READ  : fresh;
            ST_WRITE: state_d = cont ? ST_WRITE : fresh;
            default:  state_d = ST_DESEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            addr_q  <= '0;
            lanes_q <= '0;
            first_q <= 1'b1;
        end else if (force_idle) begin
            state_q <= ST_DESEL;
            first_q <= 1'b1;
        end else if (advance) begin
            state_q <= state_d;
            addr_q  <= addr;
            lanes_q <= ~lane_wr_n;
            first_q <= (state_q == ST_DESEL);
        end
    end

    // pending write commits on the next enabled, non-forced edge
    always_comb wr_fire = advance && (state_q == ST_WRITE);

    // R5: a stalled edge holds command state
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !force_idle) |=>
            ($stable(state_q) && $stable(addr_q) && $stable(lanes_q)));

    // R10: continue keeps the previous class
    a_r10_cont_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cont) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/ftlw_lane_array.sv
module ftlw_lane_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_fire,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rword
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_fire && lane_en[g])
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = store[raddr];

        // R4: an enabled lane holds the written bits afterwards
        a_r4_lane_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && lane_en[g]) |=>
                (store[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/ftlw_sram.sv
module ftlw_sram
    import ftlw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    cont,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive_en
);

    localparam int WORD_W = LANES * LANE_W;

    logic              force_idle, asleep, first_q, wr_fire;
    op_e               cur_op;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic [WORD_W-1:0] rd_word;

    ftlw_sleep_ctl u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .force_idle (force_idle),
        .asleep     (asleep)
    );

    ftlw_cmd_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_n   (clk_en_n),
        .force_idle (force_idle),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .cont       (cont),
        .we_n       (we_n),
        .lane_wr_n  (lane_wr_n),
        .addr       (addr),
        .state_q    (cur_op),
        .addr_q     (addr_q),
        .lanes_q    (lanes_q),
        .first_q    (first_q),
        .wr_fire    (wr_fire)
    );

    ftlw_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .waddr   (addr_q),
        .lane_en (lanes_q),
        .wdata   (wdata),
        .raddr   (addr_q),
        .rword   (rd_word)
    );

    always_comb begin
        drive_en = (cur_op == ST_READ) && !first_q && !oe_n;
        rdata    = drive_en ? rd_word : '0;
    end

    // R11: the command machine is idle whenever the power machine sleeps
    a_r11_idle_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (cur_op == ST_DESEL));

    // R6: no drive in a write data cycle
    a_r6_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == ST_WRITE) |-> !drive_en);

endmodule

// File: tb/ftlw_sram_bench.sv
module ftlw_sram_bench;

    localparam logic [2:0] ACT = 3'b010;  // {cs1_n, cs2, cs3_n} all active
    localparam logic [2:0] OFF = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic        cont = 1'b0, we_n = 1'b1, oe_n = 1'b0, slp = 1'b0;
    logic [3:0]  lane_wr_n = 4'hF, addr = '0;
    logic [35:0] wdata = '0, rdata;
    logic        drive_en;

    int total = 0, bad = 0;

    logic [35:0] ref_mem [16];
    int          m_state = 0;   // 0 deselect, 1 read, 2 write
    bit          m_first = 1'b1;
    logic [3:0]  m_addr = '0, m_lanes = '0;
    int          b_pw = 0;      // 0 awake, 1 enter, 2 asleep, 3 leave

    always #2 clk = ~clk;

    ftlw_sram u_ftlw_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .cont(cont), .we_n(we_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .sleep(slp), .rdata(rdata), .drive_en(drive_en)
    );

    function automatic logic [35:0] pat(input int s);
        return {s[3:0], 32'(s) * 32'h9E3779B1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic en_n, input logic cn, input logic [2:0] cs,
                        input logic w_n, input logic [3:0] ln_n, input logic [3:0] a,
                        input logic [35:0] d, input logic oe, input string tag);
        bit frc;
        int nxt;
        bit exp_drv;
        clk_en_n = en_n; cont = cn; {cs1_n, cs2, cs3_n} = cs; we_n = w_n;
        lane_wr_n = ln_n; addr = a; wdata = d; oe_n = oe;
        @(posedge clk);
        frc = (b_pw >= 2) || (b_pw == 1 && slp);
        if (frc) begin
            m_state = 0; m_first = 1'b1;
        end else if (!en_n) begin
            if (m_state == 2)
                for (int i = 0; i < 4; i++)
                    if (m_lanes[i]) ref_mem[m_addr][i*9 +: 9] = d[i*9 +: 9];
            if (cn) nxt = m_state;
            else if (cs == ACT) nxt = w_n ? 1 : 2;
            else nxt = 0;
            m_first = (m_state == 0);
            m_state = nxt; m_addr = a; m_lanes = ~ln_n;
        end
        case (b_pw)
            0: b_pw = slp ? 1 : 0;
            1: b_pw = slp ? 2 : 0;
            2: b_pw = slp ? 2 : 3;
            default: b_pw = slp ? 2 : 0;
        endcase
        #1;
        exp_drv = (m_state == 1) && !m_first && !oe;
        chk(drive_en == exp_drv, {tag, " drive"}, 36'(drive_en), 36'(exp_drv));
        chk(rdata == (exp_drv ? ref_mem[m_addr] : 36'h0), {tag, " data"}, rdata,
            exp_drv ? ref_mem[m_addr] : 36'h0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] ln_n, input logic [35:0] d,
                      input string tag);
        step(1'b0, 1'b0, ACT, 1'b0, ln_n, a, d, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input logic [35:0] d, input string tag);
        step(1'b0, 1'b0, ACT, 1'b1, 4'hF, a, d, 1'b0, tag);
    endtask

    task automatic desel(input logic [35:0] d, input string tag);
        step(1'b0, 1'b0, OFF, 1'b1, 4'hF, 4'h0, d, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(drive_en == 1'b0, "R9 reset drive", 36'(drive_en), 36'h0);
        chk(rdata == 36'h0, "R9 reset data", rdata, 36'h0);
        rst_n = 1'b1;
        desel(36'h0, "R9 idle");

        // back-to-back fill, data one edge after address (R3)
        for (int a = 0; a < 16; a++)
            wr(4'(a), 4'h0, (a == 0) ? 36'h0 : pat(a - 1), "R3 fill");
        desel(pat(15), "R6 deselect");

        // read sweep; first after deselect stays undriven (R7)
        for (int a = 0; a < 16; a++)
            rd(4'(a), 36'h0, (a == 0) ? "R7 first" : "R2 read");
        oe_n = 1'b1; #1;
        chk(drive_en == 1'b0, "R8 async oe", 36'(drive_en), 36'h0);
        oe_n = 1'b0; #1;
        chk(rdata == ref_mem[15], "R8 oe back", rdata, ref_mem[15]);
        step(1'b0, 1'b0, ACT, 1'b1, 4'hF, 4'd4, 36'h0, 1'b1, "R8 oe high");

        // every lane mask, each followed by a read of the same word (R4, R3)
        for (int m = 0; m < 16; m++) begin
            wr(4'(m), 4'(m), 36'h0, "R4 lanes");
            rd(4'(m), pat(100 + m), "R4 merged");
        end

        // write, write, read to one address back to back (R3)
        wr(4'd6, 4'b1100, 36'h0, "R3 w1");
        wr(4'd6, 4'b0011, pat(201), "R3 w2");
        rd(4'd6, pat(202), "R3 newest");

        // stalls between write address and data (R5)
        wr(4'd3, 4'h0, 36'h0, "R5 wr");
        step(1'b1, 1'b0, ACT, 1'b1, 4'h0, 4'd9, 36'hFFFFFFFFF, 1'b0, "R5 stall");
        step(1'b1, 1'b1, OFF, 1'b0, 4'h0, 4'd1, 36'h123456789, 1'b0, "R5 stall");
        rd(4'd3, pat(210), "R5 late data");
        rd(4'd5, 36'h0, "R5 rd");
        step(1'b1, 1'b0, OFF, 1'b0, 4'h0, 4'd0, 36'h0, 1'b0, "R5 read held");
        rd(4'd5, 36'h0, "R5 after stall");

        // continue cycles ignore selects and write flag (R10)
        wr(4'd8, 4'h0, 36'h0, "R10 wr");
        step(1'b0, 1'b1, OFF, 1'b1, 4'h0, 4'd9, pat(300), 1'b0, "R10 cont wr");
        step(1'b0, 1'b1, OFF, 1'b1, 4'h0, 4'd10, pat(301), 1'b0, "R10 cont wr");
        rd(4'd8, pat(302), "R10 rd");
        step(1'b0, 1'b1, OFF, 1'b0, 4'h0, 4'd9, 36'h0, 1'b0, "R10 cont rd");
        step(1'b0, 1'b1, ACT, 1'b0, 4'h0, 4'd10, 36'h0, 1'b0, "R10 cont rd");
        desel(36'h0, "R6 desel");
        step(1'b0, 1'b1, ACT, 1'b1, 4'hF, 4'd9, 36'h0, 1'b0, "R10 cont desel");
        rd(4'd9, 36'h0, "R7 first");
        rd(4'd10, 36'h0, "R2 read");

        // each select inactive on its own blocks the write (R1)
        step(1'b0, 1'b0, 3'b110, 1'b0, 4'h0, 4'd11, 36'h0, 1'b0, "R1 cs1");
        step(1'b0, 1'b0, 3'b000, 1'b0, 4'h0, 4'd11, 36'h0, 1'b0, "R1 cs2");
        step(1'b0, 1'b0, 3'b011, 1'b0, 4'h0, 4'd11, pat(400), 1'b0, "R1 cs3");
        step(1'b0, 1'b0, 3'b011, 1'b1, 4'hF, 4'd11, pat(401), 1'b0, "R1 rd blocked");
        rd(4'd11, pat(402), "R1 first");
        rd(4'd11, 36'h0, "R1 unchanged");

        // one-edge sleep pulse has no effect (R11)
        slp = 1'b1;
        rd(4'd2, 36'h0, "R11 pulse");
        slp = 1'b0;
        rd(4'd3, 36'h0, "R11 pulse ok");

        // sleep entry drops the pending write, contents survive (R11)
        slp = 1'b1;
        wr(4'd7, 4'h0, 36'h0, "R11 enter");
        rd(4'd2, pat(500), "R11 dropped");
        for (int k = 0; k < 3; k++) rd(4'd2, 36'h0, "R11 asleep");
        slp = 1'b0;
        rd(4'd7, 36'h0, "R11 leave1");
        rd(4'd7, 36'h0, "R11 leave2");
        rd(4'd7, 36'h0, "R11 first");
        rd(4'd7, 36'h0, "R11 kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule